// File: doc/BRIEF.md
# Scanner Carriage Motion Sequencer

This block steps the carriage of a flatbed scanner. From a start command it feeds the carriage to the scan window, then advances it at scan rate until the scan ends. If the image buffer fills during the scan, the carriage either backs up a programmed number of steps or holds still. When the scan is over, it can return to the home position on its own. Each motion phase emits one-cycle step pulses paced by an external period. The block also drives a direction output and a motor power enable, and it gives a 3-bit index that selects one of five acceleration/deceleration tables kept outside the block.

The return home stops in one of two ways. It can count a programmed number of steps, or it can watch for a chosen transition of the home sensor and then run a short fixed deceleration run before halting. The home sensor is synchronised through two flip-flops, and the edge detector is registered. Clearing the power control forces the sequencer back to idle at once.

Top module: `carriage_seq`

## Requirements
- R1: After reset the sequencer is idle: `step_pulse` is 0, `motor_en` is 0 and `table_sel` is 0. In idle `table_sel` stays 0. `motor_en` follows `motor_on` one clock later.
- R2: While `motor_on` is 0, the next clock puts the sequencer in idle. No step pulse follows, and `start` is ignored.
- R3: A `start` pulse in idle with power on begins the feed. The feed makes `feed_steps` steps with `dir_out` equal to `dir_rev` (0 forward, 1 reverse) and then enters the scan phase. A count of 0 acts as 1.
- R4: During the feed with `fast_two` = 0, every step uses table 1. With `fast_two` = 1, table 1 is used while the remaining count, including the current step, is greater than half of `feed_steps` (rounded down), and table 2 is used after that.
- R5: Step pulses are one cycle wide and come every max(`step_period`,1) cycles. The first pulse of a phase falls in the `step_period`-th cycle after the phase is entered.
- R6: The scan phase steps with table 0 and `dir_out` = `dir_rev` while `buf_full` is low. A `scan_done` pulse ends the scan.
- R7: With `backtrack_off` = 0, `buf_full` high during the scan starts a backtrack. The backtrack makes `back_steps` steps with table 3 in the opposite direction, and the scan then resumes.
- R8: With `backtrack_off` = 1, `buf_full` high during the scan gives no step pulses. The carriage stays in the scan phase and resumes scan steps when `buf_full` falls.
- R9: With `go_home_en` = 0, `scan_done` returns the sequencer to idle with no further steps.
- R10: With `go_home_en` = 1, `scan_done` starts the return home. The return uses table 4 with `dir_out` = not `dir_rev`.
- R11: With `home_by_count` = 1, the return home makes exactly `home_steps` steps and then goes idle. The home sensor is ignored.
- R12: With `home_by_count` = 0, the return home continues until the selected sensor edge: rising when `home_fall` = 0, falling when it is 1. It then makes DECEL_STEPS (default 2) steps with table 2 in the return direction and goes idle. The opposite edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| motor_on | input | 1 | Motor power and phase enable |
| dir_rev | input | 1 | Scan direction: 0 forward, 1 reverse |
| fast_two | input | 1 | Feed with two tables instead of one |
| go_home_en | input | 1 | Return home automatically after the scan |
| home_by_count | input | 1 | Return stops on step count (1) or sensor edge (0) |
| home_fall | input | 1 | Sensor edge select: 0 rising, 1 falling |
| backtrack_off | input | 1 | Hold instead of backtracking on a full buffer |
| start | input | 1 | Pulse that begins the feed |
| scan_done | input | 1 | Pulse that ends the scan |
| buf_full | input | 1 | Image buffer full flag |
| home_sensor | input | 1 | Raw home sensor level |
| feed_steps | input | 24 | Steps to reach the scan window |
| back_steps | input | 24 | Steps per backtrack |
| home_steps | input | 24 | Steps for a counted return home |
| step_period | input | 16 | Cycles between step pulses |
| step_pulse | output | 1 | One-cycle step pulse |
| dir_out | output | 1 | Motion direction |
| motor_en | output | 1 | Motor power enable |
| table_sel | output | 3 | Ramp table index, 0 to 4 |

## Verification
A phase begins on the clock edge after the command that causes it. The first step pulse of the phase then appears in the `step_period`-th cycle. A sensor transition changes the phase three edges after it is first sampled. A scoreboard holds the expected table and direction of every step pulse and compares them at each falling edge, so a pulse that arrives early, late or unexpected is reported against the item it should match. Stimuli are applied only after the queue has drained just past a step. With a period of 5, each phase change therefore takes effect before the next step is due. Quiet windows count pulses directly.

// File: rtl/carriage_pkg.sv
package carriage_pkg;
  localparam int CNT_W = 24;
  localparam int PER_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FEED  = 3'd1,
    ST_SCAN  = 3'd2,
    ST_BACK  = 3'd3,
    ST_HOME  = 3'd4,
    ST_DECEL = 3'd5
  } mstate_t;

  localparam logic [2:0] TBL_SCAN   = 3'd0;
  localparam logic [2:0] TBL_FEED_A = 3'd1;
  localparam logic [2:0] TBL_FEED_B = 3'd2;
  localparam logic [2:0] TBL_BACK   = 3'd3;
  localparam logic [2:0] TBL_HOME   = 3'd4;
  localparam logic [2:0] TBL_DECEL  = 3'd2;

  function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
    return (p == '0) ? PER_W'(1) : p;
  endfunction

  function automatic logic [2:0] feed_table(input logic [CNT_W-1:0] rem,
                                            input logic [CNT_W-1:0] total,
                                            input logic two);
    if (!two) return TBL_FEED_A;
    return (rem > (total >> 1)) ? TBL_FEED_A : TBL_FEED_B;
  endfunction

  function automatic logic is_moving(input mstate_t s);
    return s != ST_IDLE;
  endfunction
endpackage

// File: rtl/home_edge_det.sv
module home_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sensor,
  input  logic fall_sel,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      edge_hit <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], sensor};
      prev_q   <= synced;
      edge_hit <= fall_sel ? (prev_q & ~synced) : (~prev_q & synced);
    end
  end

  a_r12_rise_caught: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_sel && $rose(synced)) |=> edge_hit);
  a_r12_fall_caught: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_sel && $fell(synced)) |=> edge_hit);
endmodule

// File: rtl/step_pacer.sv
module step_pacer
  import carriage_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;

  assign tick = run && (cnt_q == eff_period(period) - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + PER_W'(1);
  end

  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > PER_W'(1)) |=> (!tick || !$stable(period)));
endmodule

// File: rtl/step_tally.sv
module step_tally
  import carriage_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] remaining,
  output logic             last
);
  assign last = (remaining <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          remaining <= '0;
    else if (load)                       remaining <= load_val;
    else if (dec && remaining != '0)     remaining <= remaining - CNT_W'(1);
  end
endmodule

// File: rtl/carriage_seq.sv
module carriage_seq
  import carriage_pkg::*;
#(
  parameter int DECEL_STEPS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             motor_on,
  input  logic             dir_rev,
  input  logic             fast_two,
  input  logic             go_home_en,
  input  logic             home_by_count,
  input  logic             home_fall,
  input  logic             backtrack_off,
  input  logic             start,
  input  logic             scan_done,
  input  logic             buf_full,
  input  logic             home_sensor,
  input  logic [CNT_W-1:0] feed_steps,
  input  logic [CNT_W-1:0] back_steps,
  input  logic [CNT_W-1:0] home_steps,
  input  logic [PER_W-1:0] step_period,
  output logic             step_pulse,
  output logic             dir_out,
  output logic             motor_en,
  output logic [2:0]       table_sel
);
  localparam logic [CNT_W-1:0] DECEL_CNT = CNT_W'(DECEL_STEPS);

  mstate_t          st, nxt;
  logic             edge_hit, tick, run, restart, last;
  logic [CNT_W-1:0] remaining, load_val, feed_total_q;
  logic             pwr_q;

  home_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sensor(home_sensor),
    .fall_sel(home_fall), .edge_hit(edge_hit)
  );

  assign run     = is_moving(st) && !(st == ST_SCAN && buf_full);
  assign restart = (nxt != st);

  step_pacer u_pace (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .period(step_period), .tick(tick)
  );

  step_tally u_tally (
    .clk(clk), .rst_n(rst_n), .load(restart), .load_val(load_val),
    .dec(tick), .remaining(remaining), .last(last)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (start) nxt = ST_FEED;
      ST_FEED:  if (tick && last) nxt = ST_SCAN;
      ST_SCAN: begin
        if (scan_done)                     nxt = go_home_en ? ST_HOME : ST_IDLE;
        else if (buf_full && !backtrack_off) nxt = ST_BACK;
      end
      ST_BACK:  if (tick && last) nxt = ST_SCAN;
      ST_HOME: begin
        if (home_by_count) begin
          if (tick && last) nxt = ST_IDLE;
        end else if (edge_hit) begin
          nxt = ST_DECEL;
        end
      end
      ST_DECEL: if (tick && last) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (!motor_on) nxt = ST_IDLE;
  end

  always_comb begin
    unique case (nxt)
      ST_FEED:  load_val = feed_steps;
      ST_BACK:  load_val = back_steps;
      ST_HOME:  load_val = home_steps;
      ST_DECEL: load_val = DECEL_CNT;
      default:  load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      pwr_q        <= 1'b0;
      feed_total_q <= '0;
    end else begin
      st    <= nxt;
      pwr_q <= motor_on;
      if (nxt == ST_FEED && st != ST_FEED) feed_total_q <= feed_steps;
    end
  end

  always_comb begin
    unique case (st)
      ST_FEED:  table_sel = feed_table(remaining, feed_total_q, fast_two);
      ST_BACK:  table_sel = TBL_BACK;
      ST_HOME:  table_sel = TBL_HOME;
      ST_DECEL: table_sel = TBL_DECEL;
      default:  table_sel = TBL_SCAN;
    endcase
  end

  assign dir_out    = (st == ST_BACK || st == ST_HOME || st == ST_DECEL) ? ~dir_rev : dir_rev;
  assign step_pulse = tick;
  assign motor_en   = pwr_q;

  a_r2_power_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !motor_on |=> (st == ST_IDLE && !step_pulse));
  a_r1_step_powered: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> motor_en);
  a_r4_table_range: assert property (@(posedge clk) disable iff (!rst_n)
    table_sel <= 3'd4);
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && buf_full && backtrack_off) |-> !step_pulse);
  a_r11_count_no_decel: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOME && home_by_count) |=> st != ST_DECEL);
  a_r12_edge_decel: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOME && !home_by_count && edge_hit && motor_on) |=> st == ST_DECEL);
  a_r9_no_home: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && scan_done && !go_home_en) |=> st == ST_IDLE);
endmodule

// File: tb/carriage_seq_test.sv
module carriage_seq_test;
  logic clk = 0, rst_n = 0;
  logic motor_on = 0, dir_rev = 0, fast_two = 0, go_home_en = 0;
  logic home_by_count = 0, home_fall = 0, backtrack_off = 0;
  logic start = 0, scan_done = 0, buf_full = 0, home_sensor = 0;
  logic [23:0] feed_steps = 0, back_steps = 0, home_steps = 0;
  logic [15:0] step_period = 16'd5;
  logic step_pulse, dir_out, motor_en;
  logic [2:0] table_sel;

  int n_checks = 0, n_bad = 0;
  logic [3:0] exp_q[$];
  string      req_q[$];

  localparam int P = 5;

  always #5 clk = ~clk;

  carriage_seq uut (
    .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .dir_rev(dir_rev),
    .fast_two(fast_two), .go_home_en(go_home_en), .home_by_count(home_by_count),
    .home_fall(home_fall), .backtrack_off(backtrack_off), .start(start),
    .scan_done(scan_done), .buf_full(buf_full), .home_sensor(home_sensor),
    .feed_steps(feed_steps), .back_steps(back_steps), .home_steps(home_steps),
    .step_period(step_period), .step_pulse(step_pulse), .dir_out(dir_out),
    .motor_en(motor_en), .table_sel(table_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int tbl, input bit d, input string req);
    exp_q.push_back({d, 3'(tbl)});
    req_q.push_back(req);
  endtask

  // Monitor: every step pulse is matched against the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && step_pulse) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected step actual table=%0d dir=%0d expected no step", table_sel, dir_out);
      end else begin
        logic [3:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if ({dir_out, table_sel} != e) begin
          n_bad++;
          $display("FAIL %s step actual table=%0d dir=%0d expected table=%0d dir=%0d",
                   r, table_sel, dir_out, e[2:0], e[3]);
        end
      end
    end
  end

  task automatic drain();
    do begin @(negedge clk); #1; end while (exp_q.size() != 0);
  endtask

  task automatic pulse_scan_done();
    scan_done = 1; @(negedge clk); #1; scan_done = 0;
  endtask

  task automatic quiet(input int n, input string req);
    int c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (step_pulse) c++; end
    chk(c == 0, req, c, 0);
  endtask

  task automatic push_feed(input int n, input bit fast, input bit d);
    int eff = (n == 0) ? 1 : n;
    for (int i = 0; i < eff; i++)
      push((fast && i >= n - n / 2) ? 2 : 1, d, "R4");
  endtask

  task automatic start_feed();
    start = 1; @(negedge clk); #1; start = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    #1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(step_pulse == 0, "R1 step", step_pulse, 0);
    chk(motor_en == 0, "R1 motor_en", motor_en, 0);
    chk(table_sel == 0, "R1 table", table_sel, 0);
    rst_n = 1;
    @(negedge clk); #1;
    motor_on = 1;
    @(negedge clk);
    chk(motor_en == 1, "R1 motor_en follows", motor_en, 1);

    // Scenario A: single table, forward, counted return home (R3 R5 R6 R10 R11)
    feed_steps = 4; home_steps = 5; go_home_en = 1; home_by_count = 1;
    #1;
    push_feed(4, 0, 0);
    begin
      int k = 0;
      start = 1;
      do begin @(negedge clk); k++; if (k == 1) start = 0; end while (!step_pulse && k < 50);
      chk(k == P, "R5 first step delay", k, P);
    end
    drain();
    push(0, 0, "R6"); push(0, 0, "R6"); push(0, 0, "R6");
    drain();
    push(4, 1, "R10"); push(4, 1, "R10");
    pulse_scan_done();
    drain();
    home_sensor = 1; // ignored in count mode, R11
    push(4, 1, "R11"); push(4, 1, "R11"); push(4, 1, "R11");
    drain();
    quiet(30, "R11 stop after count");
    chk(table_sel == 0, "R1 idle table", table_sel, 0);
    home_sensor = 0;
    repeat (5) @(negedge clk); #1;

    // Scenario B: two tables, reverse, backtrack, sensor rising edge (R3 R4 R7 R12)
    dir_rev = 1; fast_two = 1; feed_steps = 6; back_steps = 3;
    home_by_count = 0; home_fall = 0;
    push_feed(6, 1, 1);
    start_feed();
    drain();
    push(0, 1, "R6"); push(0, 1, "R6");
    drain();
    push(3, 0, "R7"); push(3, 0, "R7"); push(3, 0, "R7");
    push(0, 1, "R7 resume"); push(0, 1, "R7 resume");
    buf_full = 1; @(negedge clk); #1; buf_full = 0;
    drain();
    push(4, 0, "R10"); push(4, 0, "R10"); push(4, 0, "R10");
    pulse_scan_done();
    drain();
    push(2, 0, "R12 decel"); push(2, 0, "R12 decel");
    home_sensor = 1;
    drain();
    quiet(30, "R12 stop after decel");
    chk(table_sel == 0, "R1 idle table", table_sel, 0);
    home_sensor = 0;
    repeat (5) @(negedge clk); #1;

    // Scenario C: zero feed count, hold on full buffer, falling edge (R3 R8 R12)
    dir_rev = 0; fast_two = 0; feed_steps = 0; backtrack_off = 1; home_fall = 1;
    push_feed(0, 0, 0);
    start_feed();
    drain();
    push(0, 0, "R6"); push(0, 0, "R6");
    drain();
    buf_full = 1;
    quiet(20, "R8 hold");
    buf_full = 0;
    push(0, 0, "R8 resume");
    drain();
    push(4, 1, "R10"); push(4, 1, "R10");
    pulse_scan_done();
    drain();
    home_sensor = 1; // rising edge ignored while falling is selected, R12
    push(4, 1, "R12 wrong edge"); push(4, 1, "R12 wrong edge");
    drain();
    push(2, 1, "R12 decel"); push(2, 1, "R12 decel");
    home_sensor = 0;
    drain();
    quiet(30, "R12 stop after decel");
    backtrack_off = 0;

    // Scenario D: no automatic return (R9)
    go_home_en = 0; feed_steps = 2;
    push_feed(2, 0, 0);
    start_feed();
    drain();
    push(0, 0, "R6");
    drain();
    pulse_scan_done();
    quiet(30, "R9 stays put");
    chk(table_sel == 0, "R9 idle table", table_sel, 0);

    // Scenario E: power removed mid-scan (R2)
    push_feed(2, 0, 0);
    start_feed();
    drain();
    push(0, 0, "R6");
    drain();
    motor_on = 0;
    @(negedge clk);
    chk(motor_en == 0, "R2 motor_en off", motor_en, 0);
    quiet(30, "R2 no steps");
    #1; start_feed();
    quiet(30, "R2 start ignored");
    chk(table_sel == 0, "R2 idle table", table_sel, 0);
    chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule